// File: doc/BRIEF.md
# Stored-Program Controller with Address/Data Register Memory Path

An 8-bit teaching processor core built on the classic stored-program model. Its 16-word by 8-bit memory is never accessed directly by the datapath. Every access goes through a memory address register (MAR) and a memory data register (MDR). A control state machine steps each access through those two registers.

The core holds a program counter, an instruction register and one temp register. It fetches one instruction word per pass and decodes it into an opcode, a word address and a register select. It then runs a load, store, move or halt as a fixed series of steps.

A preload port lets a test environment fill memory, normally while reset is held. Debug outputs expose every architectural register and the halt condition.

Top module: `stored_prog_ctl`

## Requirements
- R1: While `rst_ni` is low, PC, IR, MAR, MDR and the temp register all read zero and `halted_o` is low. Reset is asynchronous. After release, execution starts by fetching address 0.
- R2: Each non-halt instruction takes exactly 7 clock cycles:
  - address step: MAR takes PC;
  - read step: MDR takes the addressed word;
  - IR step: IR takes MDR and PC increments;
  - decode;
  - execute-address, execute-memory and execute-finish.
  A fetch always leaves MDR holding the instruction word itself.
- R3: PC increments by one per fetch and wraps from 15 to 0.
- R4: Instruction field layout:
  - bits [7:6] are the opcode: 00 load, 01 store, 10 move MDR to temp, 11 halt;
  - bits [5:2] are the word address;
  - bits [1:0] are the register select: 00 is temp, and any other code refers to MDR.
- R5: A load puts the address field into MAR, then the addressed word into MDR. With a select other than 00, the temp register is unchanged.
- R6: A load with select 00 also copies the loaded word into the temp register in the finish step.
- R7: A store runs its steps in this order: MDR takes the source (temp for select 00, MDR otherwise), then MAR takes the address field, then memory writes MDR at MAR. A later load from that address returns the stored value.
- R8: A move copies MDR (at that point its own instruction word) into the temp register. It ignores the address and select fields, and leaves MAR at the move's own fetch address.
- R9: A halt is recognised in decode, 4 cycles after its fetch begins. From then on `halted_o` is high and all registers hold until reset.
- R10: A preload write stores `pre_data_i` at `pre_addr_i` on the clock edge. Preload takes priority over a write by the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 4 | Preload word address |
| pre_data_i | input | 8 | Preload data |
| pc_o | output | 4 | Program counter |
| ir_o | output | 8 | Instruction register |
| mar_o | output | 4 | Memory address register |
| mdr_o | output | 8 | Memory data register |
| tmp_o | output | 8 | Temp register |
| halted_o | output | 1 | Core is parked in the halt state |

## Verification
The hardest state to reach from the ports is the PC wrap from 15 back to 0. Reaching it requires sixteen complete instruction passes with no halt in between.

The stimulus preloads a program made entirely of moves, closed by a load at address 15, and runs it for 112 cycles. The register values then show the wrap together with the load from address 0.

Store ordering is checked in two ways. A register-sourced store is later read back by a load. A store with select 01 is shown to write back its own instruction word.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  localparam int OP_W  = 2;
  localparam int SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_MOVE  = 2'b10,
    OP_HALT  = 2'b11
  } opcode_e;

  localparam logic [SEL_W-1:0] SEL_TMP = 2'b00;

  typedef enum logic [2:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_IR,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_MEM,
    ST_EXEC_DONE,
    ST_HALTED
  } ctl_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_src;
    logic ir_load;
    logic pc_inc;
    logic tmp_from_mdr;
    logic mem_we;
  } ctl_t;
endpackage

// File: rtl/ctm_mem.sv
module ctm_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              pre_we_i,
  input  logic [ADDR_W-1:0] pre_addr_i,
  input  logic [DATA_W-1:0] pre_data_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      // preload wins over a core write
      if (pre_we_i && pre_addr_i == ADDR_W'(i))     mem_q[i] <= pre_data_i;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))  mem_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/ctm_ctrl.sv
module ctm_ctrl
  import ctm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  opcode_e          op_i,
  input  logic [SEL_W-1:0] sel_i,
  output ctl_state_e       state_o,
  output ctl_t             ctl_o,
  output logic             halted_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_FETCH_ADDR: begin
        ctl_o.mar_from_pc = 1'b1;
        state_d = ST_FETCH_READ;
      end
      ST_FETCH_READ: begin
        ctl_o.mdr_from_mem = 1'b1;
        state_d = ST_FETCH_IR;
      end
      ST_FETCH_IR: begin
        ctl_o.ir_load = 1'b1;
        ctl_o.pc_inc  = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        // store: MDR takes its source before MAR is touched
        ctl_o.mdr_from_src = (op_i == OP_STORE);
        state_d = (op_i == OP_HALT) ? ST_HALTED : ST_EXEC_ADDR;
      end
      ST_EXEC_ADDR: begin
        ctl_o.mar_from_ir = (op_i == OP_LOAD) || (op_i == OP_STORE);
        state_d = ST_EXEC_MEM;
      end
      ST_EXEC_MEM: begin
        ctl_o.mdr_from_mem = (op_i == OP_LOAD);
        ctl_o.mem_we       = (op_i == OP_STORE);
        state_d = ST_EXEC_DONE;
      end
      ST_EXEC_DONE: begin
        ctl_o.tmp_from_mdr = (op_i == OP_MOVE) ||
                             ((op_i == OP_LOAD) && (sel_i == SEL_TMP));
        state_d = ST_FETCH_ADDR;
      end
      ST_HALTED: state_d = ST_HALTED;
      default:   state_d = ST_FETCH_ADDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_ADDR;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign halted_o = (state_q == ST_HALTED);

  AST_FETCH_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH_ADDR |=> state_q == ST_FETCH_READ); // R2
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALTED |=> state_q == ST_HALTED); // R9
  AST_WRITE_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.mem_we |-> $past(state_q) == ST_EXEC_ADDR); // R7
  AST_MAR_ONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_o.mar_from_pc, ctl_o.mar_from_ir})); // R2
endmodule

// File: rtl/ctm_dpath.sv
module ctm_dpath
  import ctm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [DATA_W-1:0] tmp_o,
  output opcode_e           op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mdr_q, tmp_q, src_data;

  assign op_o   = opcode_e'(ir_q[DATA_W-1 -: OP_W]);
  assign addr_o = ir_q[SEL_W +: ADDR_W];
  assign sel_o  = ir_q[SEL_W-1:0];

  assign src_data = (sel_o == SEL_TMP) ? tmp_q : mdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      tmp_q <= '0;
    end else begin
      if (ctl_i.mar_from_pc)       mar_q <= pc_q;
      else if (ctl_i.mar_from_ir)  mar_q <= addr_o;
      if (ctl_i.mdr_from_mem)      mdr_q <= rd_data_i;
      else if (ctl_i.mdr_from_src) mdr_q <= src_data;
      if (ctl_i.ir_load)           ir_q  <= mdr_q;
      if (ctl_i.pc_inc)            pc_q  <= pc_q + 1'b1;
      if (ctl_i.tmp_from_mdr)      tmp_q <= mdr_q;
    end
  end

  assign pc_o  = pc_q;
  assign ir_o  = ir_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign tmp_o = tmp_q;

  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.ir_load |=> $stable(ir_q)); // R2
  AST_TMP_FROM_MDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.tmp_from_mdr |=> tmp_q == $past(mdr_q)); // R6
endmodule

// File: rtl/stored_prog_ctl.sv
module stored_prog_ctl
  import ctm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            pre_we_i,
  input  logic [ADDR_W-1:0]               pre_addr_i,
  input  logic [OP_W+ADDR_W+SEL_W-1:0]    pre_data_i,
  output logic [ADDR_W-1:0]               pc_o,
  output logic [OP_W+ADDR_W+SEL_W-1:0]    ir_o,
  output logic [ADDR_W-1:0]               mar_o,
  output logic [OP_W+ADDR_W+SEL_W-1:0]    mdr_o,
  output logic [OP_W+ADDR_W+SEL_W-1:0]    tmp_o,
  output logic                            halted_o
);
  localparam int DATA_W = OP_W + ADDR_W + SEL_W;

  ctl_t              ctl;
  ctl_state_e        state;
  opcode_e           op;
  logic [ADDR_W-1:0] ir_addr;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] rd_data;

  ctm_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .sel_i    (sel),
    .state_o  (state),
    .ctl_o    (ctl),
    .halted_o (halted_o)
  );

  ctm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl),
    .rd_data_i (rd_data),
    .pc_o      (pc_o),
    .ir_o      (ir_o),
    .mar_o     (mar_o),
    .mdr_o     (mdr_o),
    .tmp_o     (tmp_o),
    .op_o      (op),
    .addr_o    (ir_addr),
    .sel_o     (sel)
  );

  ctm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i      (clk_i),
    .pre_we_i   (pre_we_i),
    .pre_addr_i (pre_addr_i),
    .pre_data_i (pre_data_i),
    .wr_en_i    (ctl.mem_we),
    .wr_addr_i  (mar_o),
    .wr_data_i  (mdr_o),
    .rd_addr_i  (mar_o),
    .rd_data_o  (rd_data)
  );

  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH_IR |=> pc_o == ADDR_W'($past(pc_o) + 1'b1)); // R3
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(pc_o) && $stable(ir_o) && $stable(mar_o)
                 && $stable(mdr_o) && $stable(tmp_o)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> pc_o == '0 && ir_o == '0 && mdr_o == '0 && !halted_o); // R1
endmodule

// File: tb/stored_prog_ctl_tb.sv
module stored_prog_ctl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pre_we_i = 1'b0;
  logic [3:0] pre_addr_i = '0;
  logic [7:0] pre_data_i = '0;
  logic [3:0] pc_o, mar_o;
  logic [7:0] ir_o, mdr_o, tmp_o;
  logic       halted_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  stored_prog_ctl u_dut (
    .clk_i, .rst_ni, .pre_we_i, .pre_addr_i, .pre_data_i,
    .pc_o, .ir_o, .mar_o, .mdr_o, .tmp_o, .halted_o
  );

  // program A: addr 12 = A5, addr 13 = 3C
  localparam logic [7:0] PROG_A [9] = '{
    8'h31,  // load [12] sel 01
    8'h34,  // load [13] sel 00 -> temp
    8'h78,  // store [14] from temp
    8'h94,  // move (addr 5 ignored)
    8'h7D,  // store [15] from MDR (own word)
    8'h38,  // load [14] sel 00
    8'h3D,  // load [15] sel 01
    8'h33,  // load [12] sel 11: temp untouched
    8'hC0   // halt
  };
  // {pc, ir, mar, mdr, tmp} after each 7-cycle instruction
  localparam logic [31:0] VEC [8] = '{
    {4'h1, 8'h31, 4'hC, 8'hA5, 8'h00},  // R5
    {4'h2, 8'h34, 4'hD, 8'h3C, 8'h3C},  // R6
    {4'h3, 8'h78, 4'hE, 8'h3C, 8'h3C},  // R7
    {4'h4, 8'h94, 4'h3, 8'h94, 8'h94},  // R8
    {4'h5, 8'h7D, 4'hF, 8'h7D, 8'h94},  // R7
    {4'h6, 8'h38, 4'hE, 8'h3C, 8'h3C},  // R7
    {4'h7, 8'h3D, 4'hF, 8'h7D, 8'h3C},  // R7
    {4'h8, 8'h33, 4'hC, 8'hA5, 8'h3C}   // R4
  };
  localparam string VEC_REQ [8] = '{"R5", "R6", "R7", "R8", "R7", "R7", "R7", "R4"};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req, input logic [31:0] e);
    chk(req, "pc",  32'(pc_o),  32'(e[31:28]));
    chk(req, "ir",  32'(ir_o),  32'(e[27:20]));
    chk(req, "mar", 32'(mar_o), 32'(e[19:16]));
    chk(req, "mdr", 32'(mdr_o), 32'(e[15:8]));
    chk(req, "tmp", 32'(tmp_o), 32'(e[7:0]));
  endtask

  task automatic preload(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    pre_we_i = 1'b1; pre_addr_i = a; pre_data_i = d;
    @(negedge clk_i);
    pre_we_i = 1'b0;
  endtask

  task automatic run_instr(input int cycles);
    repeat (cycles) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk_regs("R1", 32'h0);
    chk("R1", "halted", 32'(halted_o), 32'h0);

    // R10: preload under reset
    for (int i = 0; i < 16; i++) preload(4'(i), 8'h00);
    for (int i = 0; i < 9; i++) preload(4'(i), PROG_A[i]);
    preload(4'd12, 8'hA5);
    preload(4'd13, 8'h3C);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      run_instr(7);  // R2
      chk_regs(VEC_REQ[i], VEC[i]);
    end

    // R9: halt after fetch + decode
    run_instr(4);
    chk("R9", "halted", 32'(halted_o), 32'h1);
    chk_regs("R9", {4'h9, 8'hC0, 4'h8, 8'hC0, 8'h3C});
    run_instr(20);
    chk("R9", "halted_hold", 32'(halted_o), 32'h1);
    chk_regs("R9", {4'h9, 8'hC0, 4'h8, 8'hC0, 8'h3C});

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk_regs("R1", 32'h0);
    chk("R1", "halted", 32'(halted_o), 32'h0);

    // R3: sixteen passes, PC wraps 15 -> 0
    preload(4'd0, 8'h81);
    for (int i = 1; i < 15; i++) preload(4'(i), 8'h80);
    preload(4'd15, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_instr(7);
    chk_regs("R8", {4'h1, 8'h81, 4'h0, 8'h81, 8'h81});
    run_instr(7 * 15);
    chk_regs("R3", {4'h0, 8'h00, 4'h0, 8'h81, 8'h81});
    chk("R2", "halted", 32'(halted_o), 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule